// File: doc/BRIEF.md
# Parallel NAND Flash Command Front End

This block sits on the device side of a parallel NAND flash bus. It watches chip enable, command latch, address latch and write protect, and it takes a one-cycle write or read strobe on an I/O bus that is either 8 or 16 bits wide. Command bytes select the current operation. Address bytes are gathered into one byte address. When enough address cycles have arrived for the configured geometry, a read or program setup is issued to the page array through a simple request port.

Identification and status queries are answered from constants and a small status register inside the block. Page data reads fetch from the array at the current address and then step the address forward. Program data writes go to the array as write requests. The ready/busy output always reports ready.

Top module: `nand_cmd_if`

## Requirements
- R1: A write strobe with `ce_n` low and `cle` high is a command cycle, and a write strobe with `ce_n` low, `ale` high and `cle` low is an address cycle. A strobe with `ce_n` high changes no state: neither the address nor the request port is affected.
- R2: Read setup (command 0x00) and program setup (command 0x80) fire after address cycle 3 on a small-page device, after cycle 4 on a large-page device of 1 Gbit or less, and after cycle 5 on a large-page device of 2 Gbit or more. A fire produces a one-cycle `req_valid` with `req_op` 1 (read load) or 2 (program setup) and `req_addr` set to the assembled address.
- R3: Address byte k (counting from 0) is taken from `io_in[7:0]` and ORed in at bit 8k. When the second byte is taken, the whole accumulated value is shifted left by (bus bytes − 1).
- R4: Command 0x90 followed by one address cycle makes the next four reads return the maker ID, the device ID, 0xA5, and then a fourth byte. The fourth byte is 0xC0 on a small-page device. On a large-page device it is 0x15 with an 8-bit bus and 0x55 with a 16-bit bus. Further reads return 0.
- R5: After command 0x70, every read returns the status byte and leaves the address unchanged, until the next command. In the status byte, bit 7 is write-unprotect, bits 6 and 5 read 1 (ready), and the other bits read 0.
- R6: On a 16-bit bus, ID and status bytes appear on `io_out[7:0]` and `io_out[15:8]` is 0.
- R7: After a read setup has fired, each read returns `page_rdata` for address `rd_addr` and then advances `rd_addr` by the bus width in bytes. After a program setup has fired, each data write issues `req_op` 3 with the current address and `io_in` as `req_wdata`, and then advances the address the same way.
- R8: While `wp_n` is low, the write-unprotect status bit clears. While `wp_n` is high, it sets.
- R9: A read strobe with `ce_n` high, or with no output pending, returns 0. `rb_n` is always 1.
- R10: Reset, and command 0xFF, return the command to read setup with no data pending, and clear the address and the address-cycle count. After reset, `io_out` and `req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| wp_n | input | 1 | Write protect, active low |
| wr_stb | input | 1 | One-cycle write strobe |
| rd_stb | input | 1 | One-cycle read strobe |
| io_in | input | BUS_W | Bus data driven by the host |
| io_out | output | BUS_W | Bus data returned to the host, updated on reads |
| rb_n | output | 1 | Ready/busy, always ready (1) |
| req_valid | output | 1 | One-cycle request to the page array |
| req_op | output | 2 | 1 read load, 2 program setup, 3 write data |
| req_addr | output | ADDR_W | Byte address of the request |
| req_wdata | output | BUS_W | Write data of the request |
| rd_addr | output | ADDR_W | Current byte address for page reads |
| page_rdata | input | BUS_W | Array data at `rd_addr` |

## Verification
The hardest case to reach is the address rescaling on the 16-bit bus combined with the five-cycle trigger, because the shift happens partway through the sequence and is only visible once later bytes have been ORed on top. The bench drives a single command and address stream into three instances at once: small-page 8-bit, large-page 8-bit and large-page 16-bit. This lets one sequence show, cycle by cycle, each configuration firing at its own count, and show the shifted column in the wide instance. An address strobe with chip enable high is placed inside that sequence to show that it is ignored.

// File: rtl/nand_if_pkg.sv
package nand_if_pkg;
  localparam logic [7:0] OPC_READ   = 8'h00;
  localparam logic [7:0] OPC_PROG   = 8'h80;
  localparam logic [7:0] OPC_STATUS = 8'h70;
  localparam logic [7:0] OPC_IDENT  = 8'h90;
  localparam logic [7:0] OPC_RESET  = 8'hFF;

  typedef enum logic [1:0] {
    REQ_NONE   = 2'd0,
    REQ_LOAD   = 2'd1,
    REQ_PSETUP = 2'd2,
    REQ_WDATA  = 2'd3
  } req_op_e;

  typedef enum logic [1:0] {
    OUT_IDLE   = 2'd0,
    OUT_IDENT  = 2'd1,
    OUT_STATUS = 2'd2,
    OUT_DATA   = 2'd3
  } out_mode_e;
endpackage

// File: rtl/nand_addr_seq.sv
module nand_addr_seq #(
  parameter int ADDR_W = 40,
  parameter int BYTES  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [7:0]        byte_in,
  input  logic              step,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] addr_nx,
  output logic [2:0]        cnt_o
);
  logic [ADDR_W-1:0] addr_q, addr_d, merged;
  logic [2:0]        cnt_q, cnt_d;

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    merged = addr_q | (ADDR_W'(byte_in) << {cnt_q, 3'b000});
    if (clr) begin
      addr_d = '0;
      cnt_d  = '0;
    end else if (load) begin
      addr_d = (cnt_q == 3'd1) ? (merged << (BYTES - 1)) : merged;
      cnt_d  = (cnt_q == 3'd7) ? cnt_q : cnt_q + 3'd1;
    end else if (step) begin
      addr_d = addr_q + ADDR_W'(BYTES);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign addr_o  = addr_q;
  assign addr_nx = addr_d;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/nand_id_rom.sv
module nand_id_rom #(
  parameter int         BUS_W      = 8,
  parameter bit         LARGE_PAGE = 1'b0,
  parameter logic [7:0] MAKER_ID   = 8'h2C,
  parameter logic [7:0] DEVICE_ID  = 8'hF1
) (
  input  logic [1:0] idx,
  output logic [7:0] byte_o
);
  localparam logic [7:0] FILLER = 8'hA5;
  logic [7:0] fourth;

  generate
    if (LARGE_PAGE) begin : g_large
      assign fourth = (BUS_W == 16) ? 8'h55 : 8'h15;
    end else begin : g_small
      assign fourth = 8'hC0;
    end
  endgenerate

  always_comb begin
    case (idx)
      2'd0:    byte_o = MAKER_ID;
      2'd1:    byte_o = DEVICE_ID;
      2'd2:    byte_o = FILLER;
      default: byte_o = fourth;
    endcase
  end
endmodule

// File: rtl/nand_status_reg.sv
module nand_status_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wp_n,
  output logic       unprot,
  output logic [7:0] status
);
  logic unprot_q, unprot_d;

  always_comb unprot_d = wp_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unprot_q <= 1'b1;
    else        unprot_q <= unprot_d;
  end

  assign unprot = unprot_q;
  assign status = {unprot_q, 2'b11, 5'b00000};
endmodule

// File: rtl/nand_cmd_if.sv
module nand_cmd_if
  import nand_if_pkg::*;
#(
  parameter int         BUS_W      = 8,
  parameter int         ADDR_W     = 40,
  parameter bit         LARGE_PAGE = 1'b0,
  parameter bit         BIG_DEVICE = 1'b0,
  parameter logic [7:0] MAKER_ID   = 8'h2C,
  parameter logic [7:0] DEVICE_ID  = 8'hF1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              cle,
  input  logic              ale,
  input  logic              wp_n,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [BUS_W-1:0]  io_in,
  output logic [BUS_W-1:0]  io_out,
  output logic              rb_n,
  output logic              req_valid,
  output logic [1:0]        req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [BUS_W-1:0]  req_wdata,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [BUS_W-1:0]  page_rdata
);
  localparam int         BYTES = BUS_W / 8;
  localparam logic [2:0] TRIG  = LARGE_PAGE ? (BIG_DEVICE ? 3'd5 : 3'd4) : 3'd3;

  logic sel, cmd_wr, adr_wr, dat_wr, dat_rd;
  assign sel    = !ce_n;
  assign cmd_wr = sel && wr_stb && cle;
  assign adr_wr = sel && wr_stb && ale && !cle;
  assign dat_wr = sel && wr_stb && !cle && !ale;
  assign dat_rd = sel && rd_stb;

  logic [7:0]        cmd_q, cmd_d;
  out_mode_e         mode_q, mode_d;
  logic [2:0]        idx_q, idx_d;
  logic              live_q, live_d;
  logic [BUS_W-1:0]  out_q, out_d;
  logic              rv_q, rv_d;
  req_op_e           op_q, op_d;
  logic [ADDR_W-1:0] ra_q, ra_d;
  logic [BUS_W-1:0]  wd_q, wd_d;

  logic              seq_clr, seq_step;
  logic [ADDR_W-1:0] seq_addr, seq_addr_nx;
  logic [2:0]        seq_cnt;
  logic [7:0]        id_byte, status;
  logic              unprot;
  logic              is_setup;

  nand_addr_seq #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(seq_clr), .load(adr_wr),
    .byte_in(io_in[7:0]), .step(seq_step),
    .addr_o(seq_addr), .addr_nx(seq_addr_nx), .cnt_o(seq_cnt)
  );

  nand_id_rom #(.BUS_W(BUS_W), .LARGE_PAGE(LARGE_PAGE),
                .MAKER_ID(MAKER_ID), .DEVICE_ID(DEVICE_ID)) u_rom (
    .idx(idx_q[1:0]), .byte_o(id_byte)
  );

  nand_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .unprot(unprot), .status(status)
  );

  assign is_setup = (cmd_q == OPC_READ) || (cmd_q == OPC_PROG);

  always_comb begin
    cmd_d    = cmd_q;
    mode_d   = mode_q;
    idx_d    = idx_q;
    live_d   = live_q;
    out_d    = out_q;
    rv_d     = 1'b0;
    op_d     = REQ_NONE;
    ra_d     = ra_q;
    wd_d     = wd_q;
    seq_clr  = 1'b0;
    seq_step = 1'b0;

    if (cmd_wr) begin
      cmd_d   = (io_in[7:0] == OPC_RESET) ? OPC_READ : io_in[7:0];
      seq_clr = 1'b1;
      live_d  = 1'b0;
      idx_d   = '0;
      mode_d  = (io_in[7:0] == OPC_STATUS) ? OUT_STATUS : OUT_IDLE;
    end else if (adr_wr) begin
      if (seq_cnt == 3'd0 && cmd_q == OPC_IDENT) begin
        mode_d = OUT_IDENT;
        idx_d  = '0;
      end
      if (seq_cnt == TRIG - 3'd1 && is_setup) begin
        live_d = 1'b1;
        rv_d   = 1'b1;
        op_d   = (cmd_q == OPC_READ) ? REQ_LOAD : REQ_PSETUP;
        ra_d   = seq_addr_nx;
        if (cmd_q == OPC_READ) mode_d = OUT_DATA;
      end
    end else if (dat_wr && cmd_q == OPC_PROG && live_q) begin
      rv_d     = 1'b1;
      op_d     = REQ_WDATA;
      ra_d     = seq_addr;
      wd_d     = io_in;
      seq_step = 1'b1;
    end

    if (dat_rd && !wr_stb) begin
      case (mode_q)
        OUT_STATUS: out_d = BUS_W'(status);
        OUT_IDENT: begin
          if (idx_q < 3'd4) begin
            out_d = BUS_W'(id_byte);
            idx_d = idx_q + 3'd1;
          end else begin
            out_d = '0;
          end
        end
        OUT_DATA: begin
          out_d    = page_rdata;
          seq_step = 1'b1;
        end
        default: out_d = '0;
      endcase
    end else if (rd_stb && ce_n) begin
      out_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= OPC_READ;
      mode_q <= OUT_IDLE;
      idx_q  <= '0;
      live_q <= 1'b0;
      out_q  <= '0;
      rv_q   <= 1'b0;
      op_q   <= REQ_NONE;
      ra_q   <= '0;
      wd_q   <= '0;
    end else begin
      cmd_q  <= cmd_d;
      mode_q <= mode_d;
      idx_q  <= idx_d;
      live_q <= live_d;
      out_q  <= out_d;
      rv_q   <= rv_d;
      op_q   <= op_d;
      ra_q   <= ra_d;
      wd_q   <= wd_d;
    end
  end

  assign io_out    = out_q;
  assign rb_n      = 1'b1;
  assign req_valid = rv_q;
  assign req_op    = op_q;
  assign req_addr  = ra_q;
  assign req_wdata = wd_q;
  assign rd_addr   = seq_addr;
endmodule

// File: rtl/nand_cmd_if_chk.sv
module nand_cmd_if_chk
  import nand_if_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              cle,
  input logic              wr_stb,
  input logic              rd_stb,
  input logic              wp_n,
  input logic [BUS_W-1:0]  io_in,
  input logic [BUS_W-1:0]  io_out,
  input logic              req_valid,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [2:0]        seq_cnt,
  input out_mode_e         mode_q,
  input logic              unprot
);
  AST_CE_HIGH_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && ce_n) |=> (io_out == '0)); // R9

  AST_REQ_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(wr_stb && !ce_n)); // R2

  AST_WP_CLEARS_UNPROT: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |=> !unprot); // R8

  AST_RESET_CMD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !ce_n && cle && io_in[7:0] == 8'hFF) |=> (rd_addr == '0 && seq_cnt == 3'd0)); // R10

  AST_STATUS_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !wr_stb && !ce_n && mode_q == OUT_STATUS) |=> $stable(rd_addr)); // R5
endmodule

bind nand_cmd_if nand_cmd_if_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .wr_stb(wr_stb),
  .rd_stb(rd_stb), .wp_n(wp_n), .io_in(io_in), .io_out(io_out),
  .req_valid(req_valid), .rd_addr(rd_addr), .seq_cnt(seq_cnt),
  .mode_q(mode_q), .unprot(unprot)
);

// File: tb/nand_cmd_if_test.sv
module nand_cmd_if_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 40;

  logic clk, rst_n, ce_n, cle, ale, wp_n, wr_stb, rd_stb;
  logic [15:0] io_in;
  int checks, errors;
  bit done;

  logic [7:0]  io_a, io_b, wd_a, wd_b, pr_a, pr_b;
  logic [15:0] io_c, wd_c, pr_c;
  logic        rb_a, rb_b, rb_c, rv_a, rv_b, rv_c;
  logic [1:0]  op_a, op_b, op_c;
  logic [AW-1:0] ra_a, ra_b, ra_c, ad_a, ad_b, ad_c;

  function automatic logic [15:0] pg(input logic [AW-1:0] a);
    return a[15:0] ^ 16'hA5A5;
  endfunction

  assign pr_a = 8'(pg(ad_a));
  assign pr_b = 8'(pg(ad_b));
  assign pr_c = pg(ad_c);

  // small page, 8-bit
  nand_cmd_if #(.BUS_W(8), .ADDR_W(AW), .LARGE_PAGE(1'b0), .BIG_DEVICE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .wp_n(wp_n),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .io_in(io_in[7:0]), .io_out(io_a),
    .rb_n(rb_a), .req_valid(rv_a), .req_op(op_a), .req_addr(ra_a),
    .req_wdata(wd_a), .rd_addr(ad_a), .page_rdata(pr_a));
  // large page, 8-bit, small device
  nand_cmd_if #(.BUS_W(8), .ADDR_W(AW), .LARGE_PAGE(1'b1), .BIG_DEVICE(1'b0)) uut_l (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .wp_n(wp_n),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .io_in(io_in[7:0]), .io_out(io_b),
    .rb_n(rb_b), .req_valid(rv_b), .req_op(op_b), .req_addr(ra_b),
    .req_wdata(wd_b), .rd_addr(ad_b), .page_rdata(pr_b));
  // large page, 16-bit, big device
  nand_cmd_if #(.BUS_W(16), .ADDR_W(AW), .LARGE_PAGE(1'b1), .BIG_DEVICE(1'b1)) uut_w (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .wp_n(wp_n),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .io_in(io_in), .io_out(io_c),
    .rb_n(rb_c), .req_valid(rv_c), .req_op(op_c), .req_addr(ra_c),
    .req_wdata(wd_c), .rd_addr(ad_c), .page_rdata(pr_c));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic c, input logic cl, input logic al,
                     input logic w, input logic r, input logic [15:0] d);
    @(negedge clk);
    ce_n = c; cle = cl; ale = al; wr_stb = w; rd_stb = r; io_in = d;
    @(negedge clk);
    ce_n = 1'b0; cle = 1'b0; ale = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] c);  cyc(0, 1, 0, 1, 0, {8'h00, c}); endtask
  task automatic adr(input logic [7:0] a);  cyc(0, 0, 1, 1, 0, {8'h00, a}); endtask
  task automatic rd();                      cyc(0, 0, 0, 0, 1, 16'h0);      endtask

  task automatic t_reset();
    chk("R10 io_out after reset", io_c, 0);
    chk("R10 req_valid after reset", {rv_a, rv_b, rv_c}, 0);
    chk("R10 rd_addr after reset", ad_c, 0);
    chk("R9 rb_n ready", {rb_a, rb_b, rb_c}, 3'b111);
  endtask

  task automatic t_read_setup();
    cmd(8'h00);
    adr(8'h12);
    chk("R2 no fire after 1", {rv_a, rv_b, rv_c}, 0);
    adr(8'h34);
    chk("R3 16-bit column shifted", ad_c, 40'h6824);
    adr(8'h56);
    chk("R2 small fires at 3", {rv_a, op_a}, {1'b1, 2'd1});
    chk("R3 small addr", ra_a, 40'h563412);
    chk("R2 large not at 3", {rv_b, rv_c}, 0);
    adr(8'h78);
    chk("R2 large 1Gb fires at 4", {rv_b, op_b}, {1'b1, 2'd1});
    chk("R3 large addr", ra_b, 40'h78563412);
    chk("R2 big not at 4", {rv_a, rv_c}, 0);
    cyc(1, 0, 1, 1, 0, 16'h00FF);
    chk("R1 ce high address ignored", ad_c, 40'h78566824);
    chk("R1 ce high no request", {rv_a, rv_b, rv_c}, 0);
    adr(8'h9A);
    chk("R2 big fires at 5", {rv_c, op_c}, {1'b1, 2'd1});
    chk("R3 wide addr", ra_c, 40'h9A78566824);
  endtask

  task automatic t_data_read();
    logic [AW-1:0] a0, c0;
    a0 = ad_a; c0 = ad_c;
    rd();
    chk("R7 read 8-bit", io_a, 64'(8'(pg(a0))));
    chk("R7 read 16-bit", io_c, pg(c0));
    rd();
    chk("R7 read 8-bit next", io_a, 64'(8'(pg(a0 + 1))));
    chk("R7 read 16-bit next", io_c, pg(c0 + 2));
    chk("R7 16-bit step by two", ad_c, c0 + 4);
  endtask

  task automatic t_program();
    cmd(8'h80);
    adr(8'h12); adr(8'h34); adr(8'h56); adr(8'h78); adr(8'h9A);
    chk("R2 program setup op", {rv_c, op_c}, {1'b1, 2'd2});
    cyc(0, 0, 0, 1, 0, 16'hBEEF);
    chk("R7 wide write req", {rv_c, op_c, wd_c}, {1'b1, 2'd3, 16'hBEEF});
    chk("R7 wide write addr", ra_c, 40'h9A78566824);
    chk("R7 narrow write data", {rv_a, op_a, wd_a}, {1'b1, 2'd3, 8'hEF});
    cyc(0, 0, 0, 1, 0, 16'h1234);
    chk("R7 wide write addr advance", ra_c, 40'h9A78566826);
  endtask

  task automatic t_status();
    cmd(8'h70);
    rd();
    chk("R5 status 8-bit", io_a, 8'hE0);
    chk("R6 status 16-bit high zero", io_c, 16'h00E0);
    cyc(1, 0, 0, 0, 1, 16'h0);
    chk("R9 ce high read zero", io_a, 0);
    rd();
    chk("R5 status sticky", io_c, 16'h00E0);
    chk("R5 address held", ad_c, 0);
  endtask

  task automatic t_wp();
    @(negedge clk); wp_n = 1'b0;
    rd();
    rd();
    chk("R8 wp clears unprotect", io_a, 8'h60);
    @(negedge clk); wp_n = 1'b1;
    rd();
    rd();
    chk("R8 wp high sets unprotect", io_a, 8'hE0);
  endtask

  task automatic t_id();
    cmd(8'h90);
    rd();
    chk("R9 nothing pending", io_a, 0);
    adr(8'h00);
    rd(); chk("R4 maker", io_c, 16'h002C);
    rd(); chk("R4 device", io_a, 8'hF1);
    rd(); chk("R4 filler", io_b, 8'hA5);
    rd();
    chk("R4 small fourth", io_a, 8'hC0);
    chk("R4 large 8-bit fourth", io_b, 8'h15);
    chk("R6 large 16-bit fourth", io_c, 16'h0055);
    rd(); chk("R4 past end zero", io_c, 0);
  endtask

  task automatic t_reset_cmd();
    cmd(8'h00);
    adr(8'h11); adr(8'h22); adr(8'h33);
    cmd(8'hFF);
    chk("R10 reset cmd clears addr", ad_a, 0);
    chk("R10 reset cmd clears wide addr", ad_c, 0);
    rd();
    chk("R10 no data after reset cmd", io_a, 0);
    adr(8'h44); adr(8'h55); adr(8'h66);
    chk("R10 count restarted", {rv_a, ra_a}, {1'b1, 40'h665544});
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; ce_n = 1'b1; cle = 0; ale = 0; wp_n = 1'b1;
    wr_stb = 0; rd_stb = 0; io_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b0;
    t_reset();
    t_read_setup();
    t_data_read();
    t_program();
    t_status();
    t_wp();
    t_id();
    t_reset_cmd();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule